// File: doc/BRIEF.md
# Slave-Side Message Framing Engine

This block sits above a byte-level I2C slave port and turns the stream of per-byte bus events into whole messages. Each event carries four status flags (interrupt, address-received, read direction, end of transfer) and the byte that went with it. When the bus master writes, the engine collects the bytes into a receive buffer. When the transfer ends, it checks the byte count against the length implied by the message header. It then reports either a completed message, with its length and whether it is an event or a response, or a framing error.

When the master turns the bus around after a single-byte read command, the engine streams out the queued transmit message one byte per read event. If nothing is queued, it streams a three-byte filler message instead. An active-low request line tells the master that the host has something to send. The line drops when a message is queued. It rises again once the first byte of a read has gone out, or when a timeout expires. A read that stops early pulls the line low again so the master fetches the whole message again.

Top module: `slave_msg_framer`

## Requirements
- R1: After reset the request line is high, the engine is idle, and no done, error or response pulse is active.
- R2: An event with interrupt and address-received set, and with read and end clear, starts a new transfer. The next plain byte becomes byte 0. If the address byte differs from `slaveAddr`, error code 1 is reported, and framing carries on.
- R3: An end event during a receive completes the message when the byte count matches the expected length; `rxDone` pulses one cycle after that event. The expected length is byte1+2 if byte 0 bit 7 is clear, or if bits 6:5 of byte 0 are 2'b10. Otherwise bits 6:5 give the length: 2'b00 means 2, 2'b01 means 3 and 2'b11 means 0. `rxIsEvent` is byte 0 bit 7, `rxLen` is the count, and `rxRdIdx`/`rxRdByte` read the buffer.
- R4: A receive that ends with a count different from the expected length gives error code 6 and no `rxDone`.
- R5: A read-start event (interrupt, address-received and read set) right after byte 0 is legal only if byte 0 is 0x01. Otherwise the engine reports error code 3, returns to idle and drives 0xFF.
- R6: Every event with read set and end clear produces `respValid` and `respByte` one cycle later. In a legal read these are the queued bytes, from index 0 onward. An end event after all `txLen` bytes have been sent pulses `txDone`.
- R7: If `txValid` is low when a read starts, the bytes 0x02, 0x07, 0x02 are sent.
- R8: An end event after fewer bytes than the message size drives the request line low again and gives no `txDone`. The next read sends the message again from index 0.
- R9: A `reqKick` pulse drives `reqLineN` low. The line returns high on a read-start event, or after `TIMEOUT_CYC` cycles.
- R10: A flag combination that the current state does not expect gives error code 2. If this happens in any state other than idle, the engine returns to idle. In idle it stays idle.
- R11: A read event after the whole message has been sent returns 0xFF and error code 4, and the engine returns to idle.
- R12: A data byte that arrives when the receive buffer already holds `RX_DEPTH` bytes is not stored. The engine reports error code 5 and stays in receive.
- R13: An event with the interrupt flag clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slaveAddr | input | 8 | Expected address byte |
| evtValid | input | 1 | One-cycle bus event strobe |
| evtIrq | input | 1 | Event interrupt flag |
| evtEnd | input | 1 | End-of-transfer flag |
| evtRcvd | input | 1 | Address-received flag |
| evtRnw | input | 1 | Read direction flag |
| evtByte | input | 8 | Byte received with the event |
| reqKick | input | 1 | Pulse: a message was queued, request a transfer |
| txValid | input | 1 | A transmit message is queued |
| txLen | input | TX_LEN_W | Length of the queued message in bytes (at least 1) |
| txRdIdx | output | TX_LEN_W | Index of the transmit byte being read |
| txRdByte | input | 8 | Queued message byte at `txRdIdx` |
| reqLineN | output | 1 | Active-low transfer request to the master |
| respValid | output | 1 | A byte must be returned to the bus |
| respByte | output | 8 | Byte to return |
| rxDone | output | 1 | Pulse: receive message complete |
| rxIsEvent | output | 1 | Completed message is an event |
| rxLen | output | $clog2(RX_DEPTH+1) | Bytes held in the receive buffer |
| rxRdIdx | input | $clog2(RX_DEPTH) | Receive buffer read index |
| rxRdByte | output | 8 | Receive buffer byte at `rxRdIdx` |
| txDone | output | 1 | Pulse: transmit message fully sent |
| errValid | output | 1 | Pulse: error reported |
| errCode | output | 3 | Error code |

## Verification
The assertions assume a few things about the inputs. `evtValid` is a single-cycle strobe. `txLen` is at least 1 and does not change while a message is being read out. `txRdByte` follows `txRdIdx` combinationally. The stimulus meets these conditions: it issues each event as a one-cycle pulse away from the clock edge, and it serves transmit bytes from a bench-held array indexed directly by `txRdIdx`. It changes `txValid` and `txLen` only between transfers.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_FIRST = 3'd2,
    ST_SEND  = 3'd3,
    ST_RECV  = 3'd4
  } frameState_t;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_ADDR  = 3'd1,
    ERR_FLAGS = 3'd2,
    ERR_NOCMD = 3'd3,
    ERR_UNDER = 3'd4,
    ERR_OVER  = 3'd5,
    ERR_SHORT = 3'd6
  } frameErr_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic rxFirst;
    logic rxSecond;
    logic rxAppend;
    logic txStart;
    logic txNext;
    logic txRewind;
    logic reqSet;
    logic reqClr;
  } dpStrobe_t;

  localparam logic [7:0] FILL_EDGE = 8'h02;
  localparam logic [7:0] FILL_MID  = 8'h07;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam logic [7:0] READ_CMD  = 8'h01;

  function automatic logic [9:0] expectLen(input logic [7:0] b0, input logic [7:0] b1);
    if (!b0[7] || b0[6:5] == 2'b10) return {2'b00, b1} + 10'd2;
    else if (b0[6:5] == 2'b00)      return 10'd2;
    else if (b0[6:5] == 2'b01)      return 10'd3;
    else                            return 10'd0;
  endfunction

  function automatic logic [7:0] fillByte(input int unsigned idx);
    return (idx == 1) ? FILL_MID : FILL_EDGE;
  endfunction

endpackage

// File: rtl/framer_data.sv
module framer_data
  import framer_pkg::*;
#(
  parameter int RX_DEPTH    = 32,
  parameter int TX_LEN_W    = 8,
  parameter int TIMEOUT_CYC = 625000,
  localparam int RXIW = $clog2(RX_DEPTH),
  localparam int RXLW = $clog2(RX_DEPTH + 1),
  localparam int TMW  = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [7:0]          evtByte,
  input  logic                reqKick,
  input  logic                txValid,
  input  logic [TX_LEN_W-1:0] txLen,
  input  logic [7:0]          txRdByte,
  input  logic [RXIW-1:0]     rxRdIdx,
  output logic [TX_LEN_W-1:0] txPos,
  output logic [TX_LEN_W-1:0] txSize,
  output logic [7:0]          firstByte,
  output logic [7:0]          nextByte,
  output logic [RXLW-1:0]     rxPos,
  output logic [7:0]          rxByte0,
  output logic [7:0]          rxByte1,
  output logic                rxFull,
  output logic [7:0]          rxRdByte,
  output logic                reqLineN
);

  logic [7:0]     rxBuf [RX_DEPTH];
  logic           txFill;
  logic           reqActive;
  logic [TMW-1:0] reqTimer;
  logic           tmrDone;

  // receive buffer storage
  always_ff @(posedge clk) begin
    if (stb.rxFirst)                 rxBuf[0] <= evtByte;
    else if (stb.rxSecond)           rxBuf[1] <= evtByte;
    else if (stb.rxAppend && !rxFull) rxBuf[rxPos[RXIW-1:0]] <= evtByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPos <= '0;
    end else if (stb.rxFirst) begin
      rxPos <= RXLW'(1);
    end else if (stb.rxSecond) begin
      rxPos <= RXLW'(2);
    end else if (stb.rxAppend && !rxFull) begin
      rxPos <= rxPos + RXLW'(1);
    end
  end

  assign rxFull   = (rxPos == RXLW'(RX_DEPTH));
  assign rxByte0  = rxBuf[0];
  assign rxByte1  = rxBuf[1];
  assign rxRdByte = rxBuf[rxRdIdx];

  // transmit cursor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPos  <= '0;
      txSize <= '0;
      txFill <= 1'b0;
    end else if (stb.txStart) begin
      txFill <= !txValid;
      txSize <= txValid ? txLen : TX_LEN_W'(3);
      txPos  <= TX_LEN_W'(1);
    end else if (stb.txRewind) begin
      txPos <= '0;
    end else if (stb.txNext) begin
      txPos <= txPos + TX_LEN_W'(1);
    end
  end

  assign firstByte = txValid ? txRdByte : FILL_EDGE;
  assign nextByte  = txFill ? fillByte(int'(txPos)) : txRdByte;

  // request line with release timeout
  assign tmrDone = reqActive && (reqTimer == TMW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqActive <= 1'b0;
      reqTimer  <= '0;
    end else if (reqKick || stb.reqSet) begin
      reqActive <= 1'b1;
      reqTimer  <= '0;
    end else if (stb.reqClr || tmrDone) begin
      reqActive <= 1'b0;
      reqTimer  <= '0;
    end else if (reqActive) begin
      reqTimer <= reqTimer + TMW'(1);
    end
  end

  assign reqLineN = !reqActive;

  // R12
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPos <= RXLW'(RX_DEPTH));

  // R9
  req_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqLineN) |-> $past(reqKick || stb.reqSet));

  // R9
  req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqLineN) |-> $past(stb.reqClr || tmrDone));

  // R11
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPos <= txSize);

endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int RX_DEPTH = 32,
  parameter int TX_LEN_W = 8,
  localparam int RXLW = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          slaveAddr,
  input  logic                evtValid,
  input  logic                evtIrq,
  input  logic                evtEnd,
  input  logic                evtRcvd,
  input  logic                evtRnw,
  input  logic [7:0]          evtByte,
  input  logic [TX_LEN_W-1:0] txPos,
  input  logic [TX_LEN_W-1:0] txSize,
  input  logic [7:0]          firstByte,
  input  logic [7:0]          nextByte,
  input  logic [RXLW-1:0]     rxPos,
  input  logic [7:0]          rxByte0,
  input  logic [7:0]          rxByte1,
  input  logic                rxFull,
  output dpStrobe_t           stb,
  output logic                respValid,
  output logic [7:0]          respByte,
  output logic                rxDone,
  output logic                txDone,
  output logic                errValid,
  output logic [2:0]          errCode
);

  frameState_t state, nextState, curState;
  frameErr_t   errNow;
  logic        live, isStart, plainByte, readStart;
  logic        respNow, rxOk, txOk;
  logic [7:0]  byteNow;

  assign live      = evtValid && evtIrq;
  assign isStart   = evtRcvd && !evtRnw && !evtEnd;
  assign plainByte = !evtRcvd && !evtRnw && !evtEnd;
  assign readStart = evtRcvd && evtRnw && !evtEnd;
  assign curState  = isStart ? ST_IDLE : state;

  always_comb begin
    nextState = state;
    stb       = '0;
    errNow    = ERR_NONE;
    byteNow   = IDLE_BYTE;
    respNow   = 1'b0;
    rxOk      = 1'b0;
    txOk      = 1'b0;
    if (live) begin
      nextState = curState;
      unique case (curState)
        ST_IDLE: begin
          if (!isStart) errNow = ERR_FLAGS;
        end
        ST_CMD: begin
          if (plainByte) begin
            stb.rxFirst = 1'b1;
            nextState   = ST_FIRST;
          end else begin
            errNow    = ERR_FLAGS;
            nextState = ST_IDLE;
          end
        end
        ST_FIRST: begin
          if (readStart) begin
            if (rxByte0 != READ_CMD) begin
              errNow    = ERR_NOCMD;
              nextState = ST_IDLE;
            end else begin
              stb.txStart = 1'b1;
              byteNow     = firstByte;
              nextState   = ST_SEND;
            end
          end else if (plainByte) begin
            stb.rxSecond = 1'b1;
            nextState    = ST_RECV;
          end else begin
            errNow    = ERR_FLAGS;
            nextState = ST_IDLE;
          end
        end
        ST_SEND: begin
          if (evtEnd) begin
            if (txPos != txSize) begin
              stb.txRewind = 1'b1;
              stb.reqSet   = 1'b1;
            end else begin
              txOk = 1'b1;
            end
            nextState = ST_IDLE;
          end else if (!evtRnw || evtRcvd) begin
            errNow    = ERR_FLAGS;
            nextState = ST_IDLE;
          end else if (txPos < txSize) begin
            byteNow    = nextByte;
            stb.txNext = 1'b1;
          end else begin
            errNow    = ERR_UNDER;
            nextState = ST_IDLE;
          end
        end
        ST_RECV: begin
          if (evtEnd && !evtRnw) begin
            if (10'(rxPos) == expectLen(rxByte0, rxByte1)) rxOk = 1'b1;
            else errNow = ERR_SHORT;
            nextState = ST_IDLE;
          end else if (evtRnw || evtRcvd) begin
            errNow    = ERR_FLAGS;
            nextState = ST_IDLE;
          end else if (!rxFull) begin
            stb.rxAppend = 1'b1;
          end else begin
            errNow = ERR_OVER;
          end
        end
        default: nextState = ST_IDLE;
      endcase
      // new transfer: address check, cursor rewind
      if (evtRcvd && !evtRnw) begin
        nextState    = ST_CMD;
        stb.txRewind = 1'b1;
        if (evtByte != slaveAddr && errNow == ERR_NONE) errNow = ERR_ADDR;
      end
      if (readStart) stb.reqClr = 1'b1;
      respNow = evtRnw && !evtEnd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      respValid <= 1'b0;
      respByte  <= IDLE_BYTE;
      rxDone    <= 1'b0;
      txDone    <= 1'b0;
      errValid  <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      state     <= nextState;
      respValid <= respNow;
      respByte  <= byteNow;
      rxDone    <= rxOk;
      txDone    <= txOk;
      errValid  <= (errNow != ERR_NONE);
      errCode   <= errNow;
    end
  end

  // R5
  send_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && $past(state) != ST_SEND) |-> ($past(rxByte0) == READ_CMD));

  // R6
  resp_after_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(evtValid && evtIrq && evtRnw && !evtEnd));

  // R10
  err_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode != ERR_NONE));

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !rxDone);

  // R13
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(evtValid && evtIrq) |-> (!respValid && !rxDone && !txDone && !errValid));

endmodule

// File: rtl/slave_msg_framer.sv
module slave_msg_framer
  import framer_pkg::*;
#(
  parameter int RX_DEPTH    = 32,
  parameter int TX_LEN_W    = 8,
  parameter int TIMEOUT_CYC = 625000,
  localparam int RXIW = $clog2(RX_DEPTH),
  localparam int RXLW = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          slaveAddr,
  input  logic                evtValid,
  input  logic                evtIrq,
  input  logic                evtEnd,
  input  logic                evtRcvd,
  input  logic                evtRnw,
  input  logic [7:0]          evtByte,
  input  logic                reqKick,
  input  logic                txValid,
  input  logic [TX_LEN_W-1:0] txLen,
  output logic [TX_LEN_W-1:0] txRdIdx,
  input  logic [7:0]          txRdByte,
  output logic                reqLineN,
  output logic                respValid,
  output logic [7:0]          respByte,
  output logic                rxDone,
  output logic                rxIsEvent,
  output logic [RXLW-1:0]     rxLen,
  input  logic [RXIW-1:0]     rxRdIdx,
  output logic [7:0]          rxRdByte,
  output logic                txDone,
  output logic                errValid,
  output logic [2:0]          errCode
);

  dpStrobe_t           stb;
  logic [TX_LEN_W-1:0] txPos, txSize;
  logic [7:0]          firstByte, nextByte, rxByte0, rxByte1;
  logic [RXLW-1:0]     rxPos;
  logic                rxFull;

  framer_ctrl #(.RX_DEPTH(RX_DEPTH), .TX_LEN_W(TX_LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .slaveAddr(slaveAddr),
    .evtValid(evtValid), .evtIrq(evtIrq), .evtEnd(evtEnd),
    .evtRcvd(evtRcvd), .evtRnw(evtRnw), .evtByte(evtByte),
    .txPos(txPos), .txSize(txSize), .firstByte(firstByte), .nextByte(nextByte),
    .rxPos(rxPos), .rxByte0(rxByte0), .rxByte1(rxByte1), .rxFull(rxFull),
    .stb(stb), .respValid(respValid), .respByte(respByte),
    .rxDone(rxDone), .txDone(txDone), .errValid(errValid), .errCode(errCode)
  );

  framer_data #(.RX_DEPTH(RX_DEPTH), .TX_LEN_W(TX_LEN_W), .TIMEOUT_CYC(TIMEOUT_CYC)) data (
    .clk(clk), .rstN(rstN), .stb(stb), .evtByte(evtByte),
    .reqKick(reqKick), .txValid(txValid), .txLen(txLen), .txRdByte(txRdByte),
    .rxRdIdx(rxRdIdx), .txPos(txPos), .txSize(txSize),
    .firstByte(firstByte), .nextByte(nextByte),
    .rxPos(rxPos), .rxByte0(rxByte0), .rxByte1(rxByte1), .rxFull(rxFull),
    .rxRdByte(rxRdByte), .reqLineN(reqLineN)
  );

  assign txRdIdx   = txPos;
  assign rxLen     = rxPos;
  assign rxIsEvent = rxByte0[7];

endmodule

// File: tb/slave_msg_framer_test.sv
module slave_msg_framer_test;

  localparam int DEPTH = 8;
  localparam int TLW   = 8;
  localparam int TOUT  = 100;
  localparam logic [7:0] ADDR = 8'h8A;

  logic clk = 1'b0, rstN = 1'b0;
  logic evtValid = 0, evtIrq = 0, evtEnd = 0, evtRcvd = 0, evtRnw = 0;
  logic [7:0] evtByte = 0;
  logic reqKick = 0, txValid = 0;
  logic [TLW-1:0] txLen = 0;
  logic [TLW-1:0] txRdIdx;
  logic [7:0] txRdByte;
  logic reqLineN, respValid, rxDone, rxIsEvent, txDone, errValid;
  logic [7:0] respByte, rxRdByte;
  logic [3:0] rxLen;
  logic [2:0] rxRdIdx = 0;
  logic [2:0] errCode;
  logic [7:0] txMem [16];

  int checks = 0, errors = 0;
  logic cRespV, cRxDone, cTxDone, cErrV;
  logic [7:0] cResp;
  logic [2:0] cErr;

  always #4 clk = ~clk;

  assign txRdByte = txMem[txRdIdx[3:0]];

  slave_msg_framer #(.RX_DEPTH(DEPTH), .TX_LEN_W(TLW), .TIMEOUT_CYC(TOUT)) uut (
    .clk(clk), .rstN(rstN), .slaveAddr(ADDR),
    .evtValid(evtValid), .evtIrq(evtIrq), .evtEnd(evtEnd), .evtRcvd(evtRcvd),
    .evtRnw(evtRnw), .evtByte(evtByte), .reqKick(reqKick), .txValid(txValid),
    .txLen(txLen), .txRdIdx(txRdIdx), .txRdByte(txRdByte), .reqLineN(reqLineN),
    .respValid(respValid), .respByte(respByte), .rxDone(rxDone), .rxIsEvent(rxIsEvent),
    .rxLen(rxLen), .rxRdIdx(rxRdIdx), .rxRdByte(rxRdByte), .txDone(txDone),
    .errValid(errValid), .errCode(errCode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic irq, input logic e, input logic rc, input logic rw, input logic [7:0] b);
    @(negedge clk);
    evtValid = 1; evtIrq = irq; evtEnd = e; evtRcvd = rc; evtRnw = rw; evtByte = b;
    @(posedge clk); #1;
    cRespV = respValid; cResp = respByte; cRxDone = rxDone;
    cTxDone = txDone; cErrV = errValid; cErr = errCode;
    evtValid = 0; evtIrq = 0; evtEnd = 0; evtRcvd = 0; evtRnw = 0;
  endtask

  task automatic evStart(input logic [7:0] a); ev(1, 0, 1, 0, a); endtask
  task automatic evData(input logic [7:0] b);  ev(1, 0, 0, 0, b); endtask
  task automatic evRdStart();                  ev(1, 0, 1, 1, ADDR | 8'h01); endtask
  task automatic evRead();                     ev(1, 0, 0, 1, 8'h00); endtask
  task automatic evEnd();                      ev(1, 1, 0, 0, 8'h00); endtask

  task automatic kick();
    @(negedge clk); reqKick = 1; @(negedge clk); reqKick = 0;
  endtask

  task automatic loadTx();
    txMem[0] = 8'h04; txMem[1] = 8'hA1; txMem[2] = 8'hB2; txMem[3] = 8'hC3;
    txLen = 4; txValid = 1;
  endtask

  task automatic testReset();
    check(reqLineN === 1'b1, "R1 request line", int'(reqLineN), 1);
    check({respValid, rxDone, txDone, errValid} === 4'b0, "R1 pulses idle",
          int'({respValid, rxDone, txDone, errValid}), 0);
  endtask

  task automatic testRxResponse();
    evStart(ADDR);
    check(!cErrV, "R2 address match", int'(cErr), 0);
    evData(8'h02); evData(8'h02); evData(8'h11); evData(8'h22);
    evEnd();
    check(cRxDone === 1'b1, "R3 response done", int'(cRxDone), 1);
    check(rxLen == 4, "R3 response length", int'(rxLen), 4);
    check(rxIsEvent === 1'b0, "R3 response kind", int'(rxIsEvent), 0);
    rxRdIdx = 3; #1;
    check(rxRdByte == 8'h22, "R3 buffer byte", int'(rxRdByte), 8'h22);
  endtask

  task automatic testRxEvents();
    evStart(ADDR); evData(8'h80); evData(8'h33); evEnd();
    check(cRxDone && rxLen == 2 && rxIsEvent, "R3 two-byte event", int'(rxLen), 2);
    evStart(ADDR); evData(8'hA0); evData(8'h01); evData(8'h02); evEnd();
    check(cRxDone && rxLen == 3, "R3 three-byte event", int'(rxLen), 3);
    evStart(ADDR); evData(8'hC0); evData(8'h01); evData(8'h55); evEnd();
    check(cRxDone && rxLen == 3 && rxIsEvent, "R3 variable event", int'(rxLen), 3);
  endtask

  task automatic testShort();
    evStart(ADDR); evData(8'h02); evData(8'h03); evData(8'hAA); evEnd();
    check(!cRxDone && cErrV && cErr == 3'd6, "R4 short receive", int'(cErr), 6);
  endtask

  task automatic testAddrMismatch();
    evStart(8'h90);
    check(cErrV && cErr == 3'd1, "R2 address mismatch", int'(cErr), 1);
    evData(8'h80); evData(8'h44); evEnd();
    check(cRxDone === 1'b1, "R2 framing continues", int'(cRxDone), 1);
  endtask

  task automatic testNoCmd();
    evStart(ADDR); evData(8'h05); evRdStart();
    check(cErrV && cErr == 3'd3, "R5 read without command", int'(cErr), 3);
    check(cRespV && cResp == 8'hFF, "R5 idle byte", int'(cResp), 8'hFF);
    evRead();
    check(cErrV && cErr == 3'd2, "R5 back in idle", int'(cErr), 2);
  endtask

  task automatic testTxQueued();
    loadTx(); kick();
    check(reqLineN === 1'b0, "R9 request asserted", int'(reqLineN), 0);
    evStart(ADDR); evData(8'h01); evRdStart();
    check(cRespV && cResp == 8'h04, "R6 first byte", int'(cResp), 8'h04);
    check(reqLineN === 1'b1, "R9 released on first byte", int'(reqLineN), 1);
    evRead(); check(cResp == 8'hA1, "R6 byte 1", int'(cResp), 8'hA1);
    evRead(); check(cResp == 8'hB2, "R6 byte 2", int'(cResp), 8'hB2);
    evRead(); check(cResp == 8'hC3, "R6 byte 3", int'(cResp), 8'hC3);
    ev(1, 1, 0, 1, 8'h00);
    check(cTxDone === 1'b1 && !cRespV, "R6 transmit done", int'(cTxDone), 1);
  endtask

  task automatic testPremature();
    loadTx(); kick();
    evStart(ADDR); evData(8'h01); evRdStart(); evRead();
    ev(1, 1, 0, 1, 8'h00);
    check(!cTxDone, "R8 no done on early end", int'(cTxDone), 0);
    check(reqLineN === 1'b0, "R8 request reasserted", int'(reqLineN), 0);
    evStart(ADDR); evData(8'h01); evRdStart();
    check(cResp == 8'h04, "R8 resend from start", int'(cResp), 8'h04);
    evRead(); evRead(); evRead(); ev(1, 1, 0, 1, 8'h00);
    check(cTxDone === 1'b1, "R8 resend completes", int'(cTxDone), 1);
  endtask

  task automatic testFill();
    txValid = 0;
    evStart(ADDR); evData(8'h01); evRdStart();
    check(cResp == 8'h02, "R7 fill byte 0", int'(cResp), 2);
    evRead(); check(cResp == 8'h07, "R7 fill byte 1", int'(cResp), 7);
    evRead(); check(cResp == 8'h02, "R7 fill byte 2", int'(cResp), 2);
    evRead();
    check(cRespV && cResp == 8'hFF && cErr == 3'd4, "R11 underflow", int'(cResp), 8'hFF);
    evRead();
    check(cErr == 3'd2, "R11 idle after underflow", int'(cErr), 2);
  endtask

  task automatic testFlags();
    evStart(ADDR); evRead();
    check(cErrV && cErr == 3'd2, "R10 bad flags in command state", int'(cErr), 2);
    evData(8'h80); evData(8'h01); evEnd();
    check(!cRxDone && cErr == 3'd2, "R10 idle ignores bytes", int'(cRxDone), 0);
  endtask

  task automatic testOverflow();
    evStart(ADDR); evData(8'h02); evData(8'h08);
    for (int i = 0; i < 6; i++) evData(8'(8'h40 + i));
    check(!cErrV && rxLen == 8, "R12 buffer filled", int'(rxLen), 8);
    evData(8'h99);
    check(cErrV && cErr == 3'd5, "R12 overflow", int'(cErr), 5);
    check(rxLen == 8, "R12 count held", int'(rxLen), 8);
    rxRdIdx = 7; #1;
    check(rxRdByte == 8'h45, "R12 byte not stored", int'(rxRdByte), 8'h45);
    evEnd();
    check(cErr == 3'd6, "R4 overflowed message short", int'(cErr), 6);
  endtask

  task automatic testSpurious();
    evStart(ADDR); evData(8'h80);
    ev(0, 0, 0, 0, 8'h77);
    check({cRespV, cRxDone, cErrV} == 3'b0, "R13 no-irq event quiet", int'({cRespV, cRxDone, cErrV}), 0);
    ev(0, 1, 0, 0, 8'h00);
    evData(8'h12); evEnd();
    check(cRxDone && rxLen == 2, "R13 no-irq event ignored", int'(rxLen), 2);
    rxRdIdx = 1; #1;
    check(rxRdByte == 8'h12, "R13 buffer untouched", int'(rxRdByte), 8'h12);
  endtask

  task automatic testTimeout();
    kick();
    repeat (TOUT / 2) @(negedge clk);
    check(reqLineN === 1'b0, "R9 held before timeout", int'(reqLineN), 0);
    repeat (TOUT) @(negedge clk);
    check(reqLineN === 1'b1, "R9 released by timeout", int'(reqLineN), 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) txMem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testRxResponse();
    testRxEvents();
    testShort();
    testAddrMismatch();
    testNoCmd();
    testTxQueued();
    testPremature();
    testFill();
    testFlags();
    testOverflow();
    testSpurious();
    testTimeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule